// File: doc/BRIEF.md
# Soft Mute Fader

This block fades a stream of signed audio samples to silence and back. A mute request moves a linear gain, one step per output frame tick, from unity down to zero. Releasing the request moves it back up to unity with steps of the same size. Each sample that arrives with its valid flag is multiplied by the current gain, and the product is scaled back to the sample width with truncation toward zero. The scaled sample appears one clock later.

The gain is a step count between zero and 2^STEP_LOG2, where the top value means unity. It can reverse at any level. If the request is dropped part way down, the gain climbs from where it stands, so a return to unity never takes more ticks than a full transition. The mute request is only looked at on a frame tick, so a request that toggles between ticks has no effect. A status output reports that the gain has reached zero. With the default parameters a full transition takes 1024 frame ticks.

Top module: `mute_fader`

## Requirements
- R1: After reset the gain is unity (2^STEP_LOG2), `fully_muted` is low, `out_valid` is low and `out_sample` is zero.
- R2: On each cycle with `frame_tick` high and `mute_req` high, the gain falls by exactly one. At zero it stays at zero, so silence is reached after 2^STEP_LOG2 ticks.
- R3: On each cycle with `frame_tick` high and `mute_req` low, the gain rises by exactly one. At unity it stays at unity, and it never exceeds 2^STEP_LOG2.
- R4: A change of `mute_req` part way through a ramp reverses the direction from the current gain, without a restart at either end.
- R5: `mute_req` is only sampled in cycles where `frame_tick` is high. Without a tick the gain does not change, whatever `mute_req` does.
- R6: For a sample presented with `in_valid` high, the next cycle shows `out_valid` high and `out_sample` = trunc(in_sample * gain / 2^STEP_LOG2), with the quotient truncated toward zero. The gain used is the one held in the cycle the sample is presented, before any tick in that same cycle takes effect.
- R7: At unity gain the sample passes through unchanged, and at zero gain the output is exactly zero, including the most negative input.
- R8: `fully_muted` is high exactly while the gain is zero. It changes on the same clock edge as the gain.
- R9: In a cycle after `in_valid` was low, `out_valid` is low and `out_sample` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mute_req | input | 1 | High requests a fade to silence, low a fade to unity |
| frame_tick | input | 1 | One-cycle pulse per output frame; each pulse advances the gain by one step |
| in_sample | input | DATA_W (24) | Signed two's-complement input sample |
| in_valid | input | 1 | High when `in_sample` carries a sample |
| out_sample | output | DATA_W (24) | Signed scaled sample, one cycle after its input |
| out_valid | output | 1 | High for one cycle with each scaled sample |
| fully_muted | output | 1 | High while the gain is zero |

## Verification
On every cycle the assertions check the following: each tick moves the gain by at most one in the requested direction; the gain is frozen between ticks and never passes unity; valid follows the input with one cycle of latency; output holds when no sample arrives; exact pass-through at unity and zero output at zero gain; and the muted flag only rises as the result of a tick taken with mute requested. The numeric value of every intermediate product needs the bench. So do truncation toward zero for negative samples, the number of ticks to each end, and a reversal part way through a ramp. The bench sweeps every gain level of a small configuration against a set of samples, and computes each expected quotient by integer division.

// File: rtl/mute_fader_pkg.sv
package mute_fader_pkg;

  // Direction decided for the gain counter in the current cycle
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_UP   = 2'd2
  } step_dir_e;

endpackage

// File: rtl/fade_step_ctrl.sv
module fade_step_ctrl
  import mute_fader_pkg::*;
#(
  parameter int unsigned STEP_LOG2 = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mute_req,
  input  logic                 frame_tick,
  output logic [STEP_LOG2:0]   gain,
  output logic                 at_zero
);

  localparam logic [STEP_LOG2:0] FULL_GAIN = {1'b1, {STEP_LOG2{1'b0}}};
  localparam logic [STEP_LOG2:0] ONE_STEP  = {{STEP_LOG2{1'b0}}, 1'b1};

  logic [STEP_LOG2:0] gain_q;
  logic               at_full;
  step_dir_e          dir;

  // Named events, brought out for the assertions
  logic step_dn;
  logic step_up;

  assign at_zero = (gain_q == '0);
  assign at_full = (gain_q == FULL_GAIN);

  // The request only counts on a frame tick; the ends saturate
  always_comb begin
    dir = STEP_HOLD;
    if (frame_tick) begin
      if (mute_req && !at_zero)      dir = STEP_DOWN;
      else if (!mute_req && !at_full) dir = STEP_UP;
    end
  end

  assign step_dn = (dir == STEP_DOWN);
  assign step_up = (dir == STEP_UP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= FULL_GAIN;
    end else begin
      case (dir)
        STEP_DOWN: gain_q <= gain_q - ONE_STEP;
        STEP_UP:   gain_q <= gain_q + ONE_STEP;
        default:   gain_q <= gain_q;
      endcase
    end
  end

  assign gain = gain_q;

  // R3: the counter never leaves its range
  a_r3_gain_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= FULL_GAIN);

  // R5: without a tick the gain is frozen
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(gain_q));

  // R2: a tick with mute requested lowers the gain by one
  a_r2_fall_one: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && mute_req && !at_zero |=> gain_q == $past(gain_q) - ONE_STEP);

  // R2: silence is sticky while mute stays requested
  a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && mute_req && at_zero |=> at_zero);

  // R3, R4: a tick without mute raises the gain by one from any level
  a_r4_rise_one: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && !mute_req && !at_full |=> gain_q == $past(gain_q) + ONE_STEP);

  // R3: unity is sticky while mute stays released
  a_r3_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && !mute_req && at_full |=> gain_q == FULL_GAIN);

  // R2, R3: at most one step is taken per cycle
  a_r2_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_dn, step_up}));

endmodule

// File: rtl/fade_scaler.sv
module fade_scaler #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned STEP_LOG2 = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [STEP_LOG2:0]       gain,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic                     in_valid,
  output logic signed [DATA_W-1:0] out_sample,
  output logic                     out_valid
);

  // The product of a DATA_W sample and a gain of at most 2^STEP_LOG2 fits here
  localparam int unsigned PW = DATA_W + STEP_LOG2;
  localparam logic [STEP_LOG2:0]   FULL_GAIN  = {1'b1, {STEP_LOG2{1'b0}}};
  localparam logic signed [PW-1:0] ROUND_BIAS = PW'((64'd1 << STEP_LOG2) - 64'd1);

  // Multiply, then divide by 2^STEP_LOG2 with the quotient truncated toward zero
  function automatic logic signed [DATA_W-1:0] scale_toward_zero(
    input logic signed [DATA_W-1:0] s,
    input logic [STEP_LOG2:0]       g
  );
    logic signed [PW-1:0] s_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;
    s_ext  = {{(PW-DATA_W){s[DATA_W-1]}}, s};
    g_ext  = $signed({{(PW-STEP_LOG2-1){1'b0}}, g});
    prod   = s_ext * g_ext;
    biased = prod[PW-1] ? prod + ROUND_BIAS : prod;
    return biased[PW-1:STEP_LOG2];
  endfunction

  logic signed [DATA_W-1:0] scaled;
  assign scaled = scale_toward_zero(in_sample, gain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sample <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= scaled;
    end
  end

  // R6: every accepted sample yields one output a cycle later
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9: without input the output is idle and holds its value
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_sample));

  // R7: unity gain is an exact pass-through
  a_r7_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && gain == FULL_GAIN |=> out_sample == $past(in_sample));

  // R7: zero gain gives exact silence
  a_r7_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && gain == '0 |=> out_sample == '0);

  // R6: truncation toward zero never flips the sign
  a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_sample[DATA_W-1] |=> !out_sample[DATA_W-1]);

endmodule

// File: rtl/mute_fader.sv
module mute_fader #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned STEP_LOG2 = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mute_req,
  input  logic                     frame_tick,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic                     in_valid,
  output logic signed [DATA_W-1:0] out_sample,
  output logic                     out_valid,
  output logic                     fully_muted
);

  logic [STEP_LOG2:0] gain;
  logic               gain_at_zero;

  fade_step_ctrl #(
    .STEP_LOG2 (STEP_LOG2)
  ) i_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .mute_req   (mute_req),
    .frame_tick (frame_tick),
    .gain       (gain),
    .at_zero    (gain_at_zero)
  );

  fade_scaler #(
    .DATA_W    (DATA_W),
    .STEP_LOG2 (STEP_LOG2)
  ) i_scale (
    .clk        (clk),
    .rst_n      (rst_n),
    .gain       (gain),
    .in_sample  (in_sample),
    .in_valid   (in_valid),
    .out_sample (out_sample),
    .out_valid  (out_valid)
  );

  assign fully_muted = gain_at_zero;

  // R8: silence is only entered by a tick taken with mute requested
  a_r8_rise_on_mute_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fully_muted) |-> $past(mute_req) && $past(frame_tick));

  // R8: silence is only left by a tick taken with mute released
  a_r8_fall_on_release_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fully_muted) |-> !$past(mute_req) && $past(frame_tick));

endmodule

// File: tb/test_mute_fader.sv
module test_mute_fader;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 24;
  localparam int SL   = 3;
  localparam int FULL = 1 << SL;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 mute_req = 1'b0;
  logic                 frame_tick = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] out_sample;
  logic                 out_valid;
  logic                 fully_muted;

  int tests = 0;
  int fails = 0;
  int exp_gain = FULL;

  always #(CLK_PERIOD/2) clk = ~clk;

  mute_fader #(.DATA_W(DW), .STEP_LOG2(SL)) i_mute_fader (
    .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .frame_tick(frame_tick),
    .in_sample(in_sample), .in_valid(in_valid), .out_sample(out_sample),
    .out_valid(out_valid), .fully_muted(fully_muted)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic do_tick(input bit m, input string req);
    mute_req = m;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    if (m && exp_gain > 0) exp_gain--;
    else if (!m && exp_gain < FULL) exp_gain++;
    check(fully_muted == (exp_gain == 0), {req, "/R8 muted flag"},
          longint'(fully_muted), longint'(exp_gain == 0));
  endtask

  // A sample of 2^SL makes the output equal to the gain
  task automatic probe(input string req);
    in_sample = DW'(FULL);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " valid"}, longint'(out_valid), 1);
    check(longint'(out_sample) == longint'(exp_gain), {req, " gain"},
          longint'(out_sample), longint'(exp_gain));
  endtask

  task automatic send(input longint s, input string req);
    longint expv;
    expv = (s * exp_gain) / FULL;
    in_sample = DW'(s);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " valid"}, longint'(out_valid), 1);
    check(longint'(out_sample) == expv, req, longint'(out_sample), expv);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint edge_vals [6] = '{-(longint'(1) << (DW-1)), (longint'(1) << (DW-1)) - 1,
                              -1, 1, -(FULL + 1), FULL - 1};
    logic signed [DW-1:0] held;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(out_sample == '0, "R1 out_sample", longint'(out_sample), 0);
    check(fully_muted == 1'b0, "R1 fully_muted", longint'(fully_muted), 0);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R1 unity after reset");

    // R5: toggling without ticks changes nothing
    for (int i = 0; i < 6; i++) begin
      mute_req = ~mute_req;
      @(negedge clk);
    end
    mute_req = 1'b0;
    probe("R5 no tick at unity");
    mute_req = 1'b1;
    @(negedge clk);
    do_tick(1'b0, "R5 release at tick wins");
    probe("R5 tick with low request");

    // R2: full fall, one step per tick, then floor
    for (int i = 0; i < FULL; i++) begin
      check(fully_muted == 1'b0, "R2 not muted early", longint'(fully_muted), 0);
      do_tick(1'b1, "R2");
      probe("R2 falling gain");
    end
    check(fully_muted == 1'b1, "R2 muted after full ramp", longint'(fully_muted), 1);
    do_tick(1'b1, "R2 floor");
    do_tick(1'b1, "R2 floor");
    probe("R2 stays at zero");
    send(-(longint'(1) << (DW-1)), "R7 zero gain most negative");

    // R5: pulses between ticks at zero gain are ignored
    mute_req = 1'b0;
    @(negedge clk);
    mute_req = 1'b1;
    @(negedge clk);
    probe("R5 no tick at zero");

    // R3: full rise then ceiling
    for (int i = 0; i < FULL; i++) begin
      do_tick(1'b0, "R3");
      probe("R3 rising gain");
    end
    do_tick(1'b0, "R3 ceiling");
    probe("R3 stays at unity");

    // R4: reversals part way through
    repeat (3) do_tick(1'b1, "R4");
    probe("R4 fell three");
    repeat (2) do_tick(1'b0, "R4");
    probe("R4 reversed up from current level");
    repeat (5) do_tick(1'b1, "R4");
    probe("R4 reversed down");
    do_tick(1'b0, "R4");
    do_tick(1'b1, "R4");
    do_tick(1'b0, "R4");
    probe("R4 alternating");
    while (exp_gain < FULL) do_tick(1'b0, "R4 return");
    probe("R4 back to unity");

    // R6: a tick in the same cycle as a sample uses the old gain
    in_sample = DW'(FULL);
    in_valid = 1'b1;
    mute_req = 1'b1;
    frame_tick = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    frame_tick = 1'b0;
    check(longint'(out_sample) == FULL, "R6 old gain on tick cycle",
          longint'(out_sample), FULL);
    exp_gain--;
    probe("R6 new gain after tick");
    do_tick(1'b0, "R6 restore");

    // R6, R7: sweep every gain level
    for (int g = FULL; g >= 0; g--) begin
      for (int v = -40; v <= 40; v++) send(longint'(v), (g == FULL || g == 0) ? "R7 sweep" : "R6 sweep");
      foreach (edge_vals[k]) send(edge_vals[k], (g == FULL || g == 0) ? "R7 edge" : "R6 edge");
      if (g > 0) do_tick(1'b1, "R6 sweep step");
    end

    // R9: output holds while idle
    while (exp_gain < 5) do_tick(1'b0, "R9 setup");
    send(-37, "R9 last sample");
    held = out_sample;
    for (int i = 0; i < 4; i++) begin
      in_sample = DW'(i * 1000 + 77);
      @(negedge clk);
      check(out_valid == 1'b0, "R9 idle valid", longint'(out_valid), 0);
      check(out_sample == held, "R9 held sample", longint'(out_sample), longint'(held));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule